// File: doc/BRIEF.md
# Dual-Mode Parity / SEC-DED Memory Datapath

This block sits between a 64-bit host data path and a pair of 36-bit memory banks. Each bank stores 32 data bits and 4 check bits. Bits [31:0] of each bank hold the data, and bits [35:32] hold the check lane. Bank 0 carries host bits [31:0] and bank 1 carries host bits [63:32].

The block runs in one of two modes:

- **Parity mode.** Each check bit is the even parity of one data byte. A read only reports whether some byte is inconsistent; it cannot say which bit failed.
- **ECC mode.** The two banks form a single 72-bit codeword. The eight check-lane bits hold an odd-column-weight SEC-DED code over all 64 data bits. The code's low nibble goes to bank 0 and its high nibble to bank 1, so the stored width does not change.

ECC mode is selected by a configuration input. It takes effect only when a second input declares the two banks a matched pair; otherwise the pair falls back to parity mode. The write path is purely combinational. A read is captured on a one-cycle strobe, and the result appears with a valid pulse:

- one cycle later in parity mode;
- two cycles later in ECC mode, because of an extra decode stage.

The read status reports one of three outcomes: clean, corrected, or uncorrectable. An uncorrectable result also raises a one-cycle non-maskable error pulse.

Top module: `pecc_datapath`

## Requirements
- R1: In parity mode the write path puts `wr_data[32k+31:32k]` on bits [31:0] of bank k. Bit 32+j of bank k is the XOR of data byte j of that bank, so each byte together with its check bit has even weight.
- R2: In parity mode the read data is the raw 64-bit data `{bank1[31:0], bank0[31:0]}`. It is presented with `rd_valid` high for exactly one cycle, on the cycle after the `rd_strobe` cycle.
- R3: In parity mode a byte whose 8 data bits and check bit have odd total weight gives status 2'b10 (uncorrectable) and `nmi_pulse` high. All other reads give status 2'b00 (clean). Parity mode never reports 2'b01.
- R4: A flipped bit pair inside one byte in parity mode goes undetected: status 2'b00, `nmi_pulse` low, and the data is returned as stored.
- R5: ECC mode is in effect only when both `ecc_mode_cfg` and `pair_matched` are 1. With `pair_matched` at 0 the write and read paths behave as in parity mode.
- R6: In ECC mode `rd_valid` rises two cycles after the `rd_strobe` cycle and stays low on the cycle in between.
- R7: In ECC mode, reading back an unmodified written codeword returns the written data with status 2'b00.
- R8: In ECC mode any single flipped bit among the 72 stored bits is corrected. The original data is returned with status 2'b01 and `nmi_pulse` stays low.
- R9: In ECC mode any two flipped bits among the 72 stored bits give status 2'b10 with `nmi_pulse` high.
- R10: After reset, and on every cycle without a result, `rd_valid`, `rd_status` and `nmi_pulse` are all 0. Status 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_mode_cfg | input | 1 | Configuration: request ECC mode for the pair |
| pair_matched | input | 1 | The two banks form a matched pair |
| wr_data | input | 64 | Host write data |
| bank0_wdata | output | 36 | Word to store in bank 0 (check lane in [35:32]) |
| bank1_wdata | output | 36 | Word to store in bank 1 (check lane in [35:32]) |
| rd_strobe | input | 1 | Capture the bank read words this cycle |
| bank0_rdata | input | 36 | Word read from bank 0 |
| bank1_rdata | input | 36 | Word read from bank 1 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result data (corrected in ECC mode) |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| nmi_pulse | output | 1 | Non-maskable error pulse on an uncorrectable read |

## Verification
A wrong syndrome or a wrong correction mask surfaces at the ports as a wrong `rd_data` word or a wrong status. It appears two cycles after the strobe, on the first read whose error touches the bad column. For that reason every one of the 72 single-bit positions is exercised separately. A stuck or mistimed decode stage shows up as `rd_valid` arriving one cycle early, one cycle late, or never. A mis-wired check lane shows up combinationally on the bank write words, before any read is made.

// File: rtl/pecc_datapath.sv
module pecc_datapath (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ecc_mode_cfg,
  input  logic        pair_matched,
  input  logic [63:0] wr_data,
  output logic [35:0] bank0_wdata,
  output logic [35:0] bank1_wdata,
  input  logic        rd_strobe,
  input  logic [35:0] bank0_rdata,
  input  logic [35:0] bank1_rdata,
  output logic        rd_valid,
  output logic [63:0] rd_data,
  output logic [1:0]  rd_status,
  output logic        nmi_pulse
);
  localparam int DW = 64;
  localparam int CW = 8;
  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_FATAL = 2'b10;

  typedef logic [CW-1:0] col_tab_t [DW];

  function automatic col_tab_t build_cols();
    col_tab_t t;
    int n;
    n = 0;
    for (int i = 0; i < DW; i++) t[i] = '0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(v[7:0]) == w && n < DW) begin
          t[n] = v[7:0];
          n++;
        end
    return t;
  endfunction

  localparam col_tab_t HCOL = build_cols();

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c ^= HCOL[i];
    return c;
  endfunction

  function automatic logic [3:0] byte_par(input logic [31:0] d);
    logic [3:0] p;
    for (int j = 0; j < 4; j++) p[j] = ^d[8*j +: 8];
    return p;
  endfunction

  logic          ecc_on;
  logic [CW-1:0] wr_chk;
  assign ecc_on = ecc_mode_cfg & pair_matched;
  assign wr_chk = encode(wr_data);

  assign bank0_wdata = {ecc_on ? wr_chk[3:0] : byte_par(wr_data[31:0]),  wr_data[31:0]};
  assign bank1_wdata = {ecc_on ? wr_chk[7:4] : byte_par(wr_data[63:32]), wr_data[63:32]};

  logic [DW-1:0] raw_data;
  logic          par_err;
  assign raw_data = {bank1_rdata[31:0], bank0_rdata[31:0]};
  assign par_err  = |{byte_par(bank0_rdata[31:0]) ^ bank0_rdata[35:32],
                      byte_par(bank1_rdata[31:0]) ^ bank1_rdata[35:32]};

  logic          s1_valid;
  logic [DW-1:0] s1_data;
  logic [CW-1:0] s1_syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_syn   <= '0;
    end else begin
      s1_valid <= rd_strobe & ecc_on;
      if (rd_strobe & ecc_on) begin
        s1_data <= raw_data;
        s1_syn  <= encode(raw_data) ^ {bank1_rdata[35:32], bank0_rdata[35:32]};
      end
    end
  end

  logic [DW-1:0] flip;
  logic          syn_zero, syn_hit;
  always_comb begin
    for (int i = 0; i < DW; i++) flip[i] = (s1_syn == HCOL[i]);
  end
  assign syn_zero = (s1_syn == '0);
  assign syn_hit  = (|flip) | ($countones(s1_syn) == 1);

  logic out_ecc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_status <= ST_CLEAN;
      nmi_pulse <= 1'b0;
      out_ecc   <= 1'b0;
    end else if (s1_valid) begin
      rd_valid  <= 1'b1;
      rd_data   <= s1_data ^ flip;
      rd_status <= syn_zero ? ST_CLEAN : (syn_hit ? ST_FIXED : ST_FATAL);
      nmi_pulse <= !syn_zero && !syn_hit;
      out_ecc   <= 1'b1;
    end else if (rd_strobe && !ecc_on) begin
      rd_valid  <= 1'b1;
      rd_data   <= raw_data;
      rd_status <= par_err ? ST_FATAL : ST_CLEAN;
      nmi_pulse <= par_err;
      out_ecc   <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      rd_status <= ST_CLEAN;
      nmi_pulse <= 1'b0;
      out_ecc   <= 1'b0;
    end
  end

  AST_PAR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !ecc_on && !s1_valid |=> rd_valid && !out_ecc) else $error("AST_PAR_LATENCY");  // R2
  AST_PAR_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !out_ecc |-> rd_status != ST_FIXED) else $error("AST_PAR_NO_FIX");  // R3
  AST_ECC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && ecc_on |=> s1_valid ##1 (rd_valid && out_ecc)) else $error("AST_ECC_LATENCY");  // R6
  AST_NMI_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> rd_valid && rd_status == ST_FATAL) else $error("AST_NMI_FATAL");  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_status == ST_CLEAN && !nmi_pulse) else $error("AST_IDLE_QUIET");  // R10
  AST_NO_STATUS_11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status != 2'b11) else $error("AST_NO_STATUS_11");  // R10
endmodule

// File: tb/pecc_datapath_tb.sv
module pecc_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_mode_cfg = 1'b0, pair_matched = 1'b0;
  logic [63:0] wr_data = '0;
  logic [35:0] bank0_wdata, bank1_wdata;
  logic        rd_strobe = 1'b0;
  logic [35:0] bank0_rdata = '0, bank1_rdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [1:0]  rd_status;
  logic        nmi_pulse;

  int checks = 0, errors = 0;

  pecc_datapath dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] even_bits(input logic [31:0] d);
    logic [3:0] p;
    for (int j = 0; j < 4; j++) p[j] = ^d[8*j +: 8];
    return p;
  endfunction

  task automatic do_write(input logic [63:0] d, output logic [71:0] cw);
    @(negedge clk);
    wr_data = d;
    #1;
    cw = {bank1_wdata, bank0_wdata};
  endtask

  task automatic do_read(input logic [71:0] cw, input bit ecc, input string req,
                         output logic [63:0] d, output logic [1:0] st, output logic n);
    @(negedge clk);
    {bank1_rdata, bank0_rdata} = cw;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (ecc) begin
      chk({req, " R6 mid-cycle valid low"}, rd_valid, 1'b0);
      @(negedge clk);
    end
    chk({req, ecc ? " R6 valid" : " R2 valid"}, rd_valid, 1'b1);
    d = rd_data; st = rd_status; n = nmi_pulse;
    @(negedge clk);
    chk({req, " R2 valid one cycle"}, rd_valid, 1'b0);
    chk({req, " R10 idle status"}, {rd_status, nmi_pulse}, 3'b000);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", rd_valid, 1'b0);
    chk("R10 reset status", rd_status, 2'b00);
    chk("R10 reset nmi", nmi_pulse, 1'b0);
  endtask

  task automatic t_parity();
    logic [71:0] cw; logic [63:0] d; logic [1:0] st; logic n;
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h8000_0001_7F00_00FE};
    ecc_mode_cfg = 1'b0; pair_matched = 1'b1;
    foreach (pats[k]) begin
      do_write(pats[k], cw);
      chk("R1 bank0 word", cw[35:0], {even_bits(pats[k][31:0]), pats[k][31:0]});
      chk("R1 bank1 word", cw[71:36], {even_bits(pats[k][63:32]), pats[k][63:32]});
      do_read(cw, 0, "R2 clean", d, st, n);
      chk("R2 data", d, pats[k]);
      chk("R3 clean status", {st, n}, 3'b000);
    end
    do_write(64'h0123_4567_89AB_CDEF, cw);
    for (int b = 0; b < 72; b += 7) begin
      do_read(cw ^ (72'd1 << b), 0, "R3 single", d, st, n);
      chk($sformatf("R3 single flip %0d", b), {st, n}, 3'b101);
    end
    do_read(cw ^ 72'h3 ^ (72'h3 << 40), 0, "R4 same byte", d, st, n);
    chk("R4 undetected status", {st, n}, 3'b000);
    chk("R4 raw data", d, 64'h0123_4567_89AB_CDEF ^ 64'h3 ^ (64'h3 << 36));
    do_read(cw ^ 72'h101, 0, "R3 two bytes", d, st, n);
    chk("R3 two-byte status", {st, n}, 3'b101);
  endtask

  task automatic t_unmatched();
    logic [71:0] cw; logic [63:0] d; logic [1:0] st; logic n;
    ecc_mode_cfg = 1'b1; pair_matched = 1'b0;
    do_write(64'hDEAD_BEEF_0BAD_F00D, cw);
    chk("R5 parity lane bank0", cw[35:32], even_bits(32'h0BAD_F00D));
    chk("R5 parity lane bank1", cw[71:68], even_bits(32'hDEAD_BEEF));
    do_read(cw ^ (72'd1 << 5), 0, "R5 fallback", d, st, n);
    chk("R5 fallback status", {st, n}, 3'b101);
  endtask

  task automatic t_ecc();
    logic [71:0] cw; logic [63:0] d; logic [1:0] st; logic n;
    logic [63:0] pats [3] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_A5A5_5A5A, 64'h0};
    ecc_mode_cfg = 1'b1; pair_matched = 1'b1;
    foreach (pats[k]) begin
      do_write(pats[k], cw);
      do_read(cw, 1, "R7 clean", d, st, n);
      chk("R7 data", d, pats[k]);
      chk("R7 status", {st, n}, 3'b000);
      for (int b = 0; b < 72; b++) begin
        do_read(cw ^ (72'd1 << b), 1, "R8", d, st, n);
        chk($sformatf("R8 corrected data bit %0d", b), d, pats[k]);
        chk($sformatf("R8 corrected status bit %0d", b), {st, n}, 3'b010);
      end
      for (int b = 0; b < 71; b += 5) begin
        do_read(cw ^ (72'd3 << b), 1, "R9", d, st, n);
        chk($sformatf("R9 adjacent pair %0d", b), {st, n}, 3'b101);
      end
      do_read(cw ^ {1'b1, 70'd0, 1'b1}, 1, "R9", d, st, n);
      chk("R9 far pair", {st, n}, 3'b101);
      do_read(cw ^ (72'd1 << 33) ^ (72'd1 << 70), 1, "R9", d, st, n);
      chk("R9 check-bit pair", {st, n}, 3'b101);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_parity();
    t_unmatched();
    t_ecc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule